// File: doc/BRIEF.md
# Nibble-Wide DRAM Slot Sequencer

This block owns one time slot of a dynamic RAM whose data bus is four bits wide and whose address pins carry the row and the column one after the other. Each slot lasts eight clocks. A one-hot phase ring walks through eight named phases. In that time the block drives one row address and two column addresses, 2n and 2n+1. It collects two 4-bit halves and joins them into one byte. At the start of each slot the block decides whether the slot serves the display fetcher or the processor.

A display fetch takes the slot only when three conditions hold: the fetch pacing counter is at zero, the display logic flags that it wants a byte, and the hold input is low. If the hold input alone stopped an otherwise eligible fetch, the block still pulses the column-advance output, so the display address keeps moving. In every slot that does not fetch for the display, the processor address goes to the RAM. If the processor asked for a read, the assembled byte is returned to it.

The phases, in order, are PH_ROW, PH_COLA, PH_LATA, PH_HIGH, PH_COLB, PH_LATB, PH_LOW and PH_DONE. The ring has one transition: each phase hands over to the next, and PH_DONE hands back to PH_ROW.

Top module: `nibble_dram_seq`

## Requirements
- R1: While reset is low and in the first clock after it, the ring is in PH_ROW. Both strobes are high (inactive), pix_rdy and vid_step are 0, and vid_byte and cpu_data are 0.
- R2: Exactly one phase is active in every clock, and the eight phases repeat in the fixed order, so one slot lasts 8 clocks.
- R3: In PH_ROW, ram_addr equals bits 15..7 of the selected address. ras_n is low (active) from PH_COLA through PH_LOW.
- R4: From PH_COLA through PH_HIGH, ram_addr equals {0, selected address bits 6..0, 0}. cas_n is low in PH_LATA and PH_HIGH.
- R5: From PH_COLB through PH_LOW, ram_addr equals {0, selected address bits 6..0, 1}. cas_n is high in PH_COLB and low in PH_LATB and PH_LOW.
- R6: In PH_DONE and PH_ROW both strobes are high, and cas_n is never low while ras_n is high.
- R7: The assembled byte is {ram_data sampled in PH_HIGH, ram_data sampled in PH_LOW}. After a display fetch, vid_byte holds this byte and pix_rdy is 1 for exactly the PH_DONE clock.
- R8: A slot fetches for the display when, at PH_ROW, the pacing counter is 0, vid_want is 1 and fetch_hold is 0. In every other slot the selected address is cpu_addr.
- R9: With half_rate = 0 every slot is eligible for a display fetch. With half_rate = 1 the pacing counter toggles once per slot, so only every other slot is eligible, starting with the first slot after reset.
- R10: When a slot is eligible but fetch_hold is 1, vid_step is 1 in PH_DONE while pix_rdy stays 0 and vid_byte is unchanged. vid_step is 0 in slots that are not eligible.
- R11: In a slot that does not fetch for the display and has cpu_rd = 1, cpu_data is loaded with the assembled byte in PH_DONE. Otherwise cpu_data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vid_addr | input | 16 | Display fetch byte address |
| cpu_addr | input | 16 | Processor byte address |
| cpu_rd | input | 1 | Processor wants read data from this slot |
| vid_want | input | 1 | Beam is inside the pixel window on a non-spacer line |
| fetch_hold | input | 1 | Blocks the display fetch for this slot |
| half_rate | input | 1 | 1: fetch on every other slot; 0: on every slot |
| ram_data | input | 4 | RAM read nibble |
| ram_addr | output | 9 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| vid_byte | output | 8 | Last display byte fetched |
| pix_rdy | output | 1 | One-clock pulse: vid_byte was just updated |
| vid_step | output | 1 | One-clock pulse: advance the display address |
| cpu_data | output | 8 | Last byte read for the processor |

## Verification
A ring that loses or duplicates its one-hot token shows at once at the strobes. The row and column strobes stop following their eight-clock pattern within the same slot, and the address pins show a row where a column belongs. A wrong pacing counter or a wrong fetch decision shows one slot later, when pix_rdy or vid_step does not appear in PH_DONE, or appears where it should not. The RAM addresses of that slot then show the wrong source. Swapped or mis-timed nibble captures show up as a wrong vid_byte or cpu_data in the PH_DONE clock of the same slot.

// File: rtl/nds_pkg.sv
package nds_pkg;

    typedef enum logic [7:0] {
        PH_ROW  = 8'b0000_0001,
        PH_COLA = 8'b0000_0010,
        PH_LATA = 8'b0000_0100,
        PH_HIGH = 8'b0000_1000,
        PH_COLB = 8'b0001_0000,
        PH_LATB = 8'b0010_0000,
        PH_LOW  = 8'b0100_0000,
        PH_DONE = 8'b1000_0000
    } phase_e;

endpackage

// File: rtl/nds_phase_ring.sv
module nds_phase_ring
    import nds_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e ph,
    output logic   ras_n,
    output logic   cas_n
);

    // state register: rotate the token by one position per clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= PH_ROW;
        else        ph <= phase_e'({ph[6:0], ph[7]});
    end

    // strobe outputs decoded from the current phase
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        unique case (ph)
            PH_ROW:  begin ras_n = 1'b1; cas_n = 1'b1; end
            PH_COLA: begin ras_n = 1'b0; cas_n = 1'b1; end
            PH_LATA: begin ras_n = 1'b0; cas_n = 1'b0; end
            PH_HIGH: begin ras_n = 1'b0; cas_n = 1'b0; end
            PH_COLB: begin ras_n = 1'b0; cas_n = 1'b1; end
            PH_LATB: begin ras_n = 1'b0; cas_n = 1'b0; end
            PH_LOW:  begin ras_n = 1'b0; cas_n = 1'b0; end
            PH_DONE: begin ras_n = 1'b1; cas_n = 1'b1; end
            default: begin ras_n = 1'b1; cas_n = 1'b1; end
        endcase
    end

endmodule

// File: rtl/nds_slot_arbiter.sv
module nds_slot_arbiter
    import nds_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            ph,
    input  logic [ADDR_W-1:0] vid_addr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              vid_want,
    input  logic              fetch_hold,
    input  logic              half_rate,
    output logic [ADDR_W-1:0] sel_addr,
    output logic              eligible_q,
    output logic              fetch_q,
    output logic              rd_q
);

    logic              pace_q;
    logic [ADDR_W-1:0] addr_q;
    logic              eligible_now;
    logic              fetch_now;

    assign eligible_now = !pace_q && vid_want;
    assign fetch_now    = eligible_now && !fetch_hold;

    // live selection during the row phase, latched choice afterwards
    assign sel_addr = (ph == PH_ROW) ? (fetch_now ? vid_addr : cpu_addr) : addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pace_q     <= 1'b0;
            addr_q     <= '0;
            eligible_q <= 1'b0;
            fetch_q    <= 1'b0;
            rd_q       <= 1'b0;
        end else begin
            if (ph == PH_ROW) begin
                eligible_q <= eligible_now;
                fetch_q    <= fetch_now;
                rd_q       <= cpu_rd;
                addr_q     <= fetch_now ? vid_addr : cpu_addr;
            end
            if (ph == PH_DONE)
                pace_q <= half_rate ? !pace_q : 1'b0;
        end
    end

endmodule

// File: rtl/nds_nibble_merge.sv
module nds_nibble_merge
    import nds_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  phase_e             ph,
    input  logic [NIB_W-1:0]   ram_data,
    input  logic               eligible_q,
    input  logic               fetch_q,
    input  logic               rd_q,
    output logic [2*NIB_W-1:0] vid_byte,
    output logic [2*NIB_W-1:0] cpu_data,
    output logic               pix_rdy,
    output logic               vid_step
);

    logic [NIB_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q     <= '0;
            vid_byte <= '0;
            cpu_data <= '0;
            pix_rdy  <= 1'b0;
            vid_step <= 1'b0;
        end else begin
            pix_rdy  <= 1'b0;
            vid_step <= 1'b0;
            if (ph == PH_HIGH)
                hi_q <= ram_data;
            if (ph == PH_LOW) begin
                if (fetch_q)
                    vid_byte <= {hi_q, ram_data};
                else if (rd_q)
                    cpu_data <= {hi_q, ram_data};
                pix_rdy  <= fetch_q;
                vid_step <= eligible_q;
            end
        end
    end

endmodule

// File: rtl/nibble_dram_seq.sv
module nibble_dram_seq
    import nds_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int COL_W  = 7,
    parameter int NIB_W  = 4,
    localparam int ROW_W = ADDR_W - COL_W,
    localparam int PAD_W = ROW_W - COL_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  vid_addr,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_rd,
    input  logic               vid_want,
    input  logic               fetch_hold,
    input  logic               half_rate,
    input  logic [NIB_W-1:0]   ram_data,
    output logic [ROW_W-1:0]   ram_addr,
    output logic               ras_n,
    output logic               cas_n,
    output logic [2*NIB_W-1:0] vid_byte,
    output logic               pix_rdy,
    output logic               vid_step,
    output logic [2*NIB_W-1:0] cpu_data
);

    phase_e            ph;
    logic [ADDR_W-1:0] sel_addr;
    logic              eligible_q;
    logic              fetch_q;
    logic              rd_q;

    nds_phase_ring u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .ph    (ph),
        .ras_n (ras_n),
        .cas_n (cas_n)
    );

    nds_slot_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph         (ph),
        .vid_addr   (vid_addr),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .vid_want   (vid_want),
        .fetch_hold (fetch_hold),
        .half_rate  (half_rate),
        .sel_addr   (sel_addr),
        .eligible_q (eligible_q),
        .fetch_q    (fetch_q),
        .rd_q       (rd_q)
    );

    nds_nibble_merge #(.NIB_W(NIB_W)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph         (ph),
        .ram_data   (ram_data),
        .eligible_q (eligible_q),
        .fetch_q    (fetch_q),
        .rd_q       (rd_q),
        .vid_byte   (vid_byte),
        .cpu_data   (cpu_data),
        .pix_rdy    (pix_rdy),
        .vid_step   (vid_step)
    );

    logic [ROW_W-1:0] row_word;
    logic [ROW_W-1:0] col_even;
    logic [ROW_W-1:0] col_odd;

    assign row_word = sel_addr[ADDR_W-1:COL_W];
    assign col_even = {{PAD_W{1'b0}}, sel_addr[COL_W-1:0], 1'b0};
    assign col_odd  = {{PAD_W{1'b0}}, sel_addr[COL_W-1:0], 1'b1};

    // address pin output process
    always_comb begin
        ram_addr = col_odd;
        unique case (ph)
            PH_ROW:                    ram_addr = row_word;
            PH_COLA, PH_LATA, PH_HIGH: ram_addr = col_even;
            PH_COLB, PH_LATB, PH_LOW:  ram_addr = col_odd;
            PH_DONE:                   ram_addr = col_odd;
            default:                   ram_addr = col_odd;
        endcase
    end

endmodule

// File: rtl/nds_seq_chk.sv
module nds_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ph,
    input logic       ras_n,
    input logic       cas_n,
    input logic [8:0] ram_addr,
    input logic       pix_rdy,
    input logic       vid_step
);

    // R2
    ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(ph));

    // R7
    pix_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rdy |=> !pix_rdy);

    // R10
    step_with_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rdy |-> vid_step);

    // R6
    cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rdy |-> (ras_n && cas_n));

    // R4
    col_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !$past(cas_n)) |-> $stable(ram_addr));

endmodule

bind nibble_dram_seq nds_seq_chk u_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph       (ph),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .ram_addr (ram_addr),
    .pix_rdy  (pix_rdy),
    .vid_step (vid_step)
);

// File: tb/nibble_dram_seq_bench.sv
`timescale 1ns/1ps
module nibble_dram_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] vid_addr = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        vid_want = 1'b0;
    logic        fetch_hold = 1'b0;
    logic        half_rate = 1'b0;
    logic [3:0]  ram_data = '0;
    logic [8:0]  ram_addr;
    logic        ras_n;
    logic        cas_n;
    logic [7:0]  vid_byte;
    logic        pix_rdy;
    logic        vid_step;
    logic [7:0]  cpu_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    bit       pace_m = 1'b0;
    bit [7:0] vb_m = '0;
    bit [7:0] cd_m = '0;

    always #10 clk = ~clk;

    nibble_dram_seq u_nibble_dram_seq (
        .clk(clk), .rst_n(rst_n), .vid_addr(vid_addr), .cpu_addr(cpu_addr),
        .cpu_rd(cpu_rd), .vid_want(vid_want), .fetch_hold(fetch_hold),
        .half_rate(half_rate), .ram_data(ram_data), .ram_addr(ram_addr),
        .ras_n(ras_n), .cas_n(cas_n), .vid_byte(vid_byte), .pix_rdy(pix_rdy),
        .vid_step(vid_step), .cpu_data(cpu_data)
    );

    // fields: vid_addr, cpu_addr, want, hold, half, rd
    localparam logic [35:0] VEC [9] = '{
        {16'h5A3C, 16'h1234, 4'b1001},
        {16'h7FFF, 16'h8001, 4'b1101},
        {16'h0080, 16'hABCD, 4'b0001},
        {16'h3001, 16'h4567, 4'b0000},
        {16'h1111, 16'h2222, 4'b1011},
        {16'h6F80, 16'h9ABC, 4'b1011},
        {16'h0001, 16'hFF7F, 4'b1010},
        {16'h4444, 16'h5555, 4'b1111},
        {16'h7E7E, 16'h0F0F, 4'b1110}
    };

    function automatic logic [3:0] nib(input logic [8:0] row, input logic [8:0] col);
        return (row[3:0] + col[7:4]) ^ col[3:0] ^ {3'b000, row[8]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // entry: just after a negedge, design in PH_ROW
    task automatic run_slot(input logic [15:0] va, input logic [15:0] ca,
                            input bit want, input bit hold, input bit half, input bit rd);
        bit          elig;
        bit          fetch;
        logic [15:0] sel;
        logic [8:0]  row_e, c0_e, c1_e;
        logic [3:0]  n0, n1;
        vid_addr = va; cpu_addr = ca; vid_want = want;
        fetch_hold = hold; half_rate = half; cpu_rd = rd;
        elig  = !pace_m && want;
        fetch = elig && !hold;
        sel   = fetch ? va : ca;
        row_e = sel[15:7];
        c0_e  = {1'b0, sel[6:0], 1'b0};
        c1_e  = {1'b0, sel[6:0], 1'b1};
        n0 = nib(row_e, c0_e);
        n1 = nib(row_e, c1_e);
        #1;
        // PH_ROW
        chk(ram_addr == row_e, "R3/R8 row address", 32'(ram_addr), 32'(row_e));
        chk(ras_n && cas_n, "R6 strobes idle in row phase", {ras_n, cas_n}, 2'b11);
        @(negedge clk);
        // PH_COLA
        chk(ram_addr == c0_e, "R4 even column", 32'(ram_addr), 32'(c0_e));
        chk({ras_n, cas_n} == 2'b01, "R3 row strobe on", {ras_n, cas_n}, 2'b01);
        ram_data = n0;
        @(negedge clk);
        // PH_LATA
        chk({ras_n, cas_n} == 2'b00, "R4 column strobe A", {ras_n, cas_n}, 2'b00);
        @(negedge clk);
        // PH_HIGH
        @(negedge clk);
        // PH_COLB
        chk(ram_addr == c1_e, "R5 odd column", 32'(ram_addr), 32'(c1_e));
        chk({ras_n, cas_n} == 2'b01, "R5 column strobe released", {ras_n, cas_n}, 2'b01);
        ram_data = n1;
        @(negedge clk);
        // PH_LATB
        chk({ras_n, cas_n} == 2'b00, "R5 column strobe B", {ras_n, cas_n}, 2'b00);
        @(negedge clk);
        // PH_LOW
        @(negedge clk);
        // PH_DONE
        if (fetch) vb_m = {n0, n1};
        else if (rd) cd_m = {n0, n1};
        chk({ras_n, cas_n} == 2'b11, "R6 strobes released at slot end", {ras_n, cas_n}, 2'b11);
        chk(pix_rdy == fetch, "R7/R8 pix_rdy", 32'(pix_rdy), 32'(fetch));
        chk(vid_step == elig, "R10/R9 vid_step", 32'(vid_step), 32'(elig));
        chk(vid_byte == vb_m, "R7/R10 vid_byte", 32'(vid_byte), 32'(vb_m));
        chk(cpu_data == cd_m, "R11 cpu_data", 32'(cpu_data), 32'(cd_m));
        pace_m = half ? !pace_m : 1'b0;
        @(negedge clk);
        #1;
        chk(pix_rdy == 1'b0, "R7 pix_rdy single clock", 32'(pix_rdy), 0);
        chk(vid_step == 1'b0, "R2 slot restarts", 32'(vid_step), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk({ras_n, cas_n} == 2'b11, "R1 strobes in reset", {ras_n, cas_n}, 2'b11);
        chk(!pix_rdy && !vid_step, "R1 pulses in reset", {pix_rdy, vid_step}, 0);
        chk(vid_byte == 0 && cpu_data == 0, "R1 data in reset", {vid_byte, cpu_data}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 9; i++)
            run_slot(VEC[i][35:20], VEC[i][19:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);

        // directed: reset in mid slot returns ring to the row phase
        run_slot(16'h2468, 16'h1357, 1'b1, 1'b0, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk({ras_n, cas_n} == 2'b11, "R1 strobes after mid-slot reset", {ras_n, cas_n}, 2'b11);
        chk(vid_byte == 0 && cpu_data == 0, "R1 data cleared", {vid_byte, cpu_data}, 0);
        pace_m = 1'b0; vb_m = '0; cd_m = '0;
        @(negedge clk);
        rst_n = 1'b1;
        // R9 first slot after reset is eligible at half rate, then next is not
        run_slot(16'h0F0F, 16'h7070, 1'b1, 1'b0, 1'b1, 1'b1);
        run_slot(16'h0F10, 16'h7071, 1'b1, 1'b0, 1'b1, 1'b1);
        run_slot(16'h7FFF, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule